// File: doc/BRIEF.md
# Virtual-Machine Branch Resolution Unit

This unit resolves control-flow instructions for a 64-bit register virtual machine. It receives one decoded jump-class instruction per cycle: the current program counter (in 64-bit instruction slots), the 4-bit operation code, the source-select bit, a class bit choosing 64-bit or 32-bit comparison, the 16-bit offset, the 32-bit immediate, the call-subtype field and the two register operand values. One cycle later it returns the next program counter, whether control was transferred, and flags for a local call, a helper call, a return and an illegal encoding.

The call and return flags are meant for an external sequencer, which owns the call stack and helper dispatch. All displacements are counted from the slot after the current instruction. That slot is PC+1, or PC+2 when the current instruction is a 128-bit wide one.

Top module: `brc_unit`

## Requirements
- R1: While `rst_ni` is low all outputs are zero. A result appears on the outputs, with `valid_o` high, exactly one clock after the cycle in which `valid_i` was high. `valid_o` is low after a cycle with `valid_i` low.
- R2: When nothing is taken, `next_pc_o` is the fall-through address: `pc_i`+1, or `pc_i`+2 when `wide_i` is high. `taken_o` is then low.
- R3: A taken conditional (codes 0x1–0x7 and 0xa–0xd) and the unconditional jump (code 0x0) in the 64-bit class (`cls64_i`=1) set `taken_o`. They set `next_pc_o` to the fall-through address plus the sign-extended 16-bit `off_i`, with wrap at `PC_W` bits.
- R4: Code 0x0 in the 32-bit class (`cls64_i`=0) jumps by the sign-extended 32-bit `imm_i` and ignores `off_i`.
- R5: The unsigned and equality conditions are: 0x1 equal, 0x5 not equal, 0x2 greater, 0x3 greater-or-equal, 0xa less, 0xb less-or-equal.
- R6: The signed conditions are: 0x6 greater, 0x7 greater-or-equal, 0xc less, 0xd less-or-equal, all in two's complement.
- R7: Code 0x4 is taken when the bitwise AND of the two operands is nonzero.
- R8: With `src_sel_i`=1 the second operand is `src_val_i`. With `src_sel_i`=0 it is `imm_i`, sign-extended to 64 bits, and this applies to the unsigned conditions as well.
- R9: In the 32-bit class only bits 31:0 of both operands are compared, and the signed conditions treat them as 32-bit signed values.
- R10: Code 0x8 in the 64-bit class is a call. If `src_reg_i`=1 it raises `call_local_o` and `taken_o` and targets the fall-through plus the sign-extended `imm_i`. If `src_reg_i` is 0 or 2 it raises `call_helper_o`, leaves `taken_o` low and gives the fall-through.
- R11: Code 0x9 in the 64-bit class raises `exit_o`, leaves `taken_o` low and gives the fall-through.
- R12: `illegal_o` is raised for each of these encodings: codes 0xe and 0xf; code 0x8 or 0x9 in the 32-bit class; code 0x0 with `src_sel_i`=1; code 0x8 with `src_reg_i` other than 0, 1 or 2. An illegal instruction is not taken, yields the fall-through and raises no other flag.
- R13: At most one of `call_local_o`, `call_helper_o`, `exit_o`, `illegal_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| pc_i | input | PC_W | Current program counter in slots |
| code_i | input | 4 | Operation code |
| src_sel_i | input | 1 | 1: register operand, 0: immediate |
| cls64_i | input | 1 | 1: 64-bit class, 0: 32-bit class |
| wide_i | input | 1 | Current instruction occupies two slots |
| src_reg_i | input | 4 | Source register field (call subtype) |
| off_i | input | 16 | Signed offset field |
| imm_i | input | 32 | Signed immediate field |
| dst_val_i | input | XLEN | First comparison operand |
| src_val_i | input | XLEN | Register second operand |
| valid_o | output | 1 | Result present |
| next_pc_o | output | PC_W | Resolved next program counter |
| taken_o | output | 1 | Control transferred |
| call_local_o | output | 1 | Program-local call |
| call_helper_o | output | 1 | Helper call request |
| exit_o | output | 1 | Return request |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The assertions assume that `valid_i` and the other inputs settle before each rising edge, and that a result is judged only in the cycle after its instruction was presented. They also assume the block decodes every code and subtype value, so illegal combinations are legal stimulus and not excluded. The stimulus changes inputs on the falling edge only. It deliberately covers all sixteen codes, both classes, both source selections and arbitrary subtype values. Operands are biased toward equal values, values equal only in their low half, and sign-boundary values, so that the width and signedness distinctions are reached.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [3:0] {
    OP_JA   = 4'h0, OP_JEQ  = 4'h1, OP_JGT  = 4'h2, OP_JGE  = 4'h3,
    OP_JSET = 4'h4, OP_JNE  = 4'h5, OP_JSGT = 4'h6, OP_JSGE = 4'h7,
    OP_CALL = 4'h8, OP_EXIT = 4'h9, OP_JLT  = 4'ha, OP_JLE  = 4'hb,
    OP_JSLT = 4'hc, OP_JSLE = 4'hd, OP_RSVE = 4'he, OP_RSVF = 4'hf
  } brc_op_e;

  typedef struct packed {
    logic is_cond;
    logic is_jump;
    logic use_imm;
    logic call_local;
    logic call_helper;
    logic is_exit;
    logic illegal;
  } brc_dec_t;
endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic       src_sel_i,
  input  logic       cls64_i,
  input  logic [3:0] src_reg_i,
  output brc_dec_t   dec_o
);
  brc_op_e op;
  logic    bad_call_sub;

  assign op           = brc_op_e'(code_i);
  assign bad_call_sub = (src_reg_i > 4'd2);

  always_comb begin
    dec_o = '0;
    unique case (op)
      OP_JA: begin
        dec_o.illegal = src_sel_i;
        dec_o.is_jump = !src_sel_i;
        dec_o.use_imm = !src_sel_i && !cls64_i;
      end
      OP_CALL: begin
        dec_o.illegal     = !cls64_i || bad_call_sub;
        dec_o.call_local  = cls64_i && (src_reg_i == 4'd1);
        dec_o.call_helper = cls64_i && ((src_reg_i == 4'd0) || (src_reg_i == 4'd2));
        dec_o.use_imm     = cls64_i && (src_reg_i == 4'd1);
      end
      OP_EXIT: begin
        dec_o.illegal = !cls64_i;
        dec_o.is_exit = cls64_i;
      end
      OP_RSVE, OP_RSVF: dec_o.illegal = 1'b1;
      default: dec_o.is_cond = 1'b1;
    endcase
  end
endmodule

// File: rtl/brc_cmp.sv
module brc_cmp
  import brc_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            cls64_i,
  input  logic [3:0]      code_i,
  output logic            cond_o
);
  localparam int unsigned HALF_W = XLEN / 2;

  // index 0: low-half compare, index 1: full-width compare
  logic [1:0] eq_w, ult_w, slt_w, any_w;

  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int unsigned W = (g == 0) ? HALF_W : XLEN;
    logic [W-1:0] a_s, b_s;
    assign a_s      = a_i[W-1:0];
    assign b_s      = b_i[W-1:0];
    assign eq_w[g]  = (a_s == b_s);
    assign ult_w[g] = (a_s < b_s);
    assign slt_w[g] = ($signed(a_s) < $signed(b_s));
    assign any_w[g] = |(a_s & b_s);
  end

  logic eq, ult, slt, any;
  assign eq  = eq_w[cls64_i];
  assign ult = ult_w[cls64_i];
  assign slt = slt_w[cls64_i];
  assign any = any_w[cls64_i];

  always_comb begin
    unique case (brc_op_e'(code_i))
      OP_JEQ:  cond_o = eq;
      OP_JNE:  cond_o = !eq;
      OP_JGT:  cond_o = !ult && !eq;
      OP_JGE:  cond_o = !ult;
      OP_JLT:  cond_o = ult;
      OP_JLE:  cond_o = ult || eq;
      OP_JSGT: cond_o = !slt && !eq;
      OP_JSGE: cond_o = !slt;
      OP_JSLT: cond_o = slt;
      OP_JSLE: cond_o = slt || eq;
      OP_JSET: cond_o = any;
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned IMM_W = 32
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic             wide_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  output logic [PC_W-1:0]  fall_o,
  output logic [PC_W-1:0]  target_o
);
  logic [PC_W-1:0] disp;

  assign fall_o = pc_i + (wide_i ? PC_W'(2) : PC_W'(1));

  always_comb begin
    if (use_imm_i) disp = PC_W'($signed(imm_i));
    else           disp = PC_W'($signed(off_i));
  end

  assign target_o = fall_o + disp;
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int unsigned PC_W = 32,
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [3:0]      code_i,
  input  logic            src_sel_i,
  input  logic            cls64_i,
  input  logic            wide_i,
  input  logic [3:0]      src_reg_i,
  input  logic [15:0]     off_i,
  input  logic [31:0]     imm_i,
  input  logic [XLEN-1:0] dst_val_i,
  input  logic [XLEN-1:0] src_val_i,
  output logic            valid_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic            taken_o,
  output logic            call_local_o,
  output logic            call_helper_o,
  output logic            exit_o,
  output logic            illegal_o
);
  localparam int unsigned IMM_W = 32;
  localparam int unsigned OFF_W = 16;

  brc_dec_t        dec;
  logic [XLEN-1:0] opnd_b;
  logic            cond;
  logic            take;
  logic [PC_W-1:0] fall, target;

  brc_decode u_dec (
    .code_i    (code_i),
    .src_sel_i (src_sel_i),
    .cls64_i   (cls64_i),
    .src_reg_i (src_reg_i),
    .dec_o     (dec)
  );

  assign opnd_b = src_sel_i ? src_val_i : XLEN'($signed(imm_i));

  brc_cmp #(.XLEN(XLEN)) u_cmp (
    .a_i     (dst_val_i),
    .b_i     (opnd_b),
    .cls64_i (cls64_i),
    .code_i  (code_i),
    .cond_o  (cond)
  );

  brc_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_tgt (
    .pc_i      (pc_i),
    .wide_i    (wide_i),
    .off_i     (off_i),
    .imm_i     (imm_i),
    .use_imm_i (dec.use_imm),
    .fall_o    (fall),
    .target_o  (target)
  );

  assign take = dec.is_jump || dec.call_local || (dec.is_cond && cond);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      next_pc_o     <= '0;
      taken_o       <= 1'b0;
      call_local_o  <= 1'b0;
      call_helper_o <= 1'b0;
      exit_o        <= 1'b0;
      illegal_o     <= 1'b0;
    end else begin
      valid_o       <= valid_i;
      next_pc_o     <= take ? target : fall;
      taken_o       <= valid_i && take;
      call_local_o  <= valid_i && dec.call_local;
      call_helper_o <= valid_i && dec.call_helper;
      exit_o        <= valid_i && dec.is_exit;
      illegal_o     <= valid_i && dec.illegal;
    end
  end
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [PC_W-1:0] pc_i,
  input logic [3:0]      code_i,
  input logic            cls64_i,
  input logic            wide_i,
  input logic            valid_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            taken_o,
  input logic            call_local_o,
  input logic            call_helper_o,
  input logic            exit_o,
  input logic            illegal_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_FALLTHRU_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (taken_o || next_pc_o == $past(pc_i) + ($past(wide_i) ? PC_W'(2) : PC_W'(1)))); // R2
  AST_EXIT_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls64_i && code_i == 4'h9) |=> (exit_o && !taken_o)); // R11
  AST_RSV_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && code_i >= 4'he) |=> illegal_o); // R12
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !taken_o); // R12
  AST_LOCAL_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_local_o |-> taken_o); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({call_local_o, call_helper_o, exit_o, illegal_o})); // R13
endmodule

bind brc_unit brc_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .pc_i          (pc_i),
  .code_i        (code_i),
  .cls64_i       (cls64_i),
  .wide_i        (wide_i),
  .valid_o       (valid_o),
  .next_pc_o     (next_pc_o),
  .taken_o       (taken_o),
  .call_local_o  (call_local_o),
  .call_helper_o (call_helper_o),
  .exit_o        (exit_o),
  .illegal_o     (illegal_o)
);

// File: tb/tb_brc_unit.sv
module tb_brc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int XLEN = 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [PC_W-1:0] pc_i = '0;
  logic [3:0]      code_i = '0;
  logic            src_sel_i = 1'b0;
  logic            cls64_i = 1'b0;
  logic            wide_i = 1'b0;
  logic [3:0]      src_reg_i = '0;
  logic [15:0]     off_i = '0;
  logic [31:0]     imm_i = '0;
  logic [XLEN-1:0] dst_val_i = '0;
  logic [XLEN-1:0] src_val_i = '0;
  logic            valid_o;
  logic [PC_W-1:0] next_pc_o;
  logic            taken_o, call_local_o, call_helper_o, exit_o, illegal_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  brc_unit #(.PC_W(PC_W), .XLEN(XLEN)) dut (.*);

  // expected result: {valid, taken, local, helper, exit, illegal}, next pc
  function automatic void model(
    input logic [3:0] c, input logic s, input logic k64, input logic w,
    input logic [3:0] sr, input logic [31:0] pc, input logic [15:0] off,
    input logic [31:0] imm, input logic [63:0] d, input logic [63:0] r,
    output logic [5:0] fl, output logic [31:0] npc);
    longint sa, sb;
    longint unsigned ua, ub;
    logic [63:0] b;
    logic tk, loc, hlp, ex, ill, cnd;
    int disp;
    int unsigned fall;
    b = s ? r : {{32{imm[31]}}, imm};
    if (k64) begin
      ua = d; ub = b; sa = $signed(d); sb = $signed(b);
    end else begin
      ua = {32'd0, d[31:0]}; ub = {32'd0, b[31:0]};
      sa = longint'($signed(d[31:0])); sb = longint'($signed(b[31:0]));
    end
    cnd = 0;
    case (c)
      4'h1: cnd = (ua == ub);
      4'h5: cnd = (ua != ub);
      4'h2: cnd = (ua > ub);
      4'h3: cnd = (ua >= ub);
      4'ha: cnd = (ua < ub);
      4'hb: cnd = (ua <= ub);
      4'h6: cnd = (sa > sb);
      4'h7: cnd = (sa >= sb);
      4'hc: cnd = (sa < sb);
      4'hd: cnd = (sa <= sb);
      4'h4: cnd = ((ua & ub) != 0);
      default: cnd = 0;
    endcase
    ill = (c >= 4'he) || (c == 4'h0 && s) || ((c == 4'h8 || c == 4'h9) && !k64)
          || (c == 4'h8 && sr > 4'd2);
    loc = !ill && c == 4'h8 && sr == 4'd1;
    hlp = !ill && c == 4'h8 && sr != 4'd1;
    ex  = !ill && c == 4'h9;
    fall = pc + (w ? 2 : 1);
    tk = 0; disp = 0;
    if (!ill && c == 4'h0) begin
      tk = 1; disp = k64 ? int'($signed(off)) : int'($signed(imm));
    end else if (loc) begin
      tk = 1; disp = int'($signed(imm));
    end else if (c != 4'h0 && c != 4'h8 && c != 4'h9 && c < 4'he && cnd) begin
      tk = 1; disp = int'($signed(off));
    end
    npc = tk ? fall + disp : fall;
    fl = {1'b1, tk, loc, hlp, ex, ill};
  endfunction

  task automatic apply(input string tag,
    input logic [3:0] c, input logic s, input logic k64, input logic w,
    input logic [3:0] sr, input logic [31:0] pc, input logic [15:0] off,
    input logic [31:0] imm, input logic [63:0] d, input logic [63:0] r);
    logic [5:0] efl, afl;
    logic [31:0] enpc;
    model(c, s, k64, w, sr, pc, off, imm, d, r, efl, enpc);
    valid_i = 1; code_i = c; src_sel_i = s; cls64_i = k64; wide_i = w;
    src_reg_i = sr; pc_i = pc; off_i = off; imm_i = imm;
    dst_val_i = d; src_val_i = r;
    @(negedge clk_i);
    afl = {valid_o, taken_o, call_local_o, call_helper_o, exit_o, illegal_o};
    checks++;
    if (afl !== efl || next_pc_o !== enpc) begin
      failures++;
      $display("FAIL %s code=%h: flags=%b pc=%0d expected flags=%b pc=%0d",
               tag, c, afl, next_pc_o, efl, enpc);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++; // R1 reset state
    if ({valid_o, taken_o, call_local_o, call_helper_o, exit_o, illegal_o} !== 6'b0 ||
        next_pc_o !== 0) begin
      failures++;
      $display("FAIL R1 reset outputs=%b pc=%0d expected 0", {valid_o, taken_o,
               call_local_o, call_helper_o, exit_o, illegal_o}, next_pc_o);
    end
    rst_ni = 1;
    @(negedge clk_i);
    // R3 R5 equal registers, offset 5
    apply("R3", 4'h1, 1, 1, 0, 0, 100, 16'd5, 0, 64'h1234, 64'h1234);
    apply("R2", 4'h1, 1, 1, 0, 0, 100, 16'd5, 0, 64'h1234, 64'h1235);
    apply("R2", 4'h1, 1, 1, 1, 0, 100, 16'd5, 0, 64'h1234, 64'h1235);
    apply("R3", 4'h0, 0, 1, 0, 0, 10, 16'hfffd, 32'd99, 0, 0);
    apply("R4", 4'h0, 0, 0, 0, 0, 0, 16'd7, 32'h10000, 0, 0);
    apply("R4", 4'h0, 0, 0, 0, 0, 1000, 16'd7, 32'hffffff00, 0, 0);
    apply("R5", 4'h2, 1, 1, 0, 0, 20, 16'd4, 0, '1, 64'd1);
    apply("R6", 4'h6, 1, 1, 0, 0, 20, 16'd4, 0, '1, 64'd1);
    apply("R6", 4'hc, 1, 1, 0, 0, 20, 16'd4, 0, '1, 64'd0);
    apply("R5", 4'hb, 1, 1, 0, 0, 20, 16'd4, 0, 64'd9, 64'd9);
    apply("R6", 4'hd, 1, 1, 0, 0, 20, 16'd4, 0, 64'd10, 64'd9);
    apply("R7", 4'h4, 1, 1, 0, 0, 30, 16'd2, 0, 64'hf0, 64'h0f);
    apply("R7", 4'h4, 1, 1, 0, 0, 30, 16'd2, 0, 64'hf0, 64'h18);
    apply("R8", 4'h1, 0, 1, 0, 0, 40, 16'd3, 32'hffffffff, '1, 64'd0);
    apply("R8", 4'ha, 0, 1, 0, 0, 40, 16'd3, 32'hffffffff, 64'd5, '1);
    apply("R9", 4'h1, 1, 0, 0, 0, 40, 16'd3, 0, 64'h1_00000005, 64'h5);
    apply("R9", 4'hc, 1, 0, 0, 0, 40, 16'd3, 0, 64'h80000000, 64'h0);
    apply("R9", 4'hc, 1, 1, 0, 0, 40, 16'd3, 0, 64'h80000000, 64'h0);
    apply("R10", 4'h8, 0, 1, 0, 4'd1, 50, 16'd9, 32'd20, 0, 0);
    apply("R10", 4'h8, 0, 1, 0, 4'd2, 50, 16'd9, 32'd20, 0, 0);
    apply("R10", 4'h8, 0, 1, 0, 4'd0, 50, 16'd9, 32'd20, 0, 0);
    apply("R11", 4'h9, 0, 1, 0, 0, 60, 16'd9, 32'd20, 0, 0);
    apply("R12", 4'he, 0, 1, 0, 0, 70, 16'd9, 32'd20, 0, 0);
    apply("R12", 4'hf, 1, 0, 1, 0, 70, 16'd9, 32'd20, 0, 0);
    apply("R12", 4'h8, 0, 0, 0, 4'd1, 70, 16'd9, 32'd20, 0, 0);
    apply("R12", 4'h9, 0, 0, 0, 0, 70, 16'd9, 32'd20, 0, 0);
    apply("R12", 4'h0, 1, 1, 0, 0, 70, 16'd9, 32'd20, 0, 0);
    apply("R12", 4'h8, 0, 1, 0, 4'd5, 70, 16'd9, 32'd20, 0, 0);
    // R1 idle cycle drops valid_o
    valid_i = 0;
    @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0 || taken_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 idle valid=%b taken=%b expected 0 0", valid_o, taken_o);
    end
    // R13 and all others: random mix with biased operands
    for (int i = 0; i < 600; i++) begin
      logic [63:0] d, r;
      logic [31:0] imm;
      int sel;
      d = rnd64(); r = rnd64(); imm = $urandom();
      sel = $urandom_range(0, 4);
      if (sel == 0) r = d;
      else if (sel == 1) r = {~d[63:32], d[31:0]};
      else if (sel == 2) imm = d[31:0];
      else if (sel == 3) d = {32'h0, 32'h80000000};
      apply("R13", 4'($urandom_range(0, 15)), 1'($urandom()), 1'($urandom()),
            1'($urandom()), 4'($urandom_range(0, 4)), $urandom(),
            16'($urandom()), imm, d, r);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule